// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns a single asynchronous serial line into parallel characters. A character on the line is a low start bit, eight data bits sent least significant bit first, an optional ninth data bit, and a high stop bit. The line is idle high. A clock-enable tick is derived from an 8-bit divisor. Each bit lasts 16 ticks in fast mode or 64 ticks in slow mode. Within that bit time the line is sampled once, at the middle.

A finished character goes into a holding register, and a ready flag rises. The reader takes the byte and pulses a read strobe, which drops the flag. The framing flag always describes the character that is currently held. If a new character finishes while the held one is still unread, an overrun flag is raised and the new character is thrown away. Nothing is loaded after that until the continuous-receive enable is dropped, which also clears the overrun flag.

Top module: `serial_rx_core`

## Requirements
- R1: One bit time lasts 16*(baud_div+1) clock cycles when fast_mode is 1 and 64*(baud_div+1) cycles when fast_mode is 0.
- R2: Characters are received only while port_en and cont_en are both 1. A frame sent while either is 0 leaves rx_valid at 0.
- R3: A character is framed as a low start bit, then data bits least significant first, then a high stop bit. Once the stop bit has been sampled, rx_data holds the byte and rx_valid is 1.
- R4: With nine_mode at 1, a ninth data bit follows the eighth and appears on rx_bit9. With nine_mode at 0, rx_bit9 of a loaded character is 0.
- R5: frame_err is 1 exactly when the stop bit of the character in rx_data was sampled low. It changes only when a character is loaded.
- R6: A character that completes while rx_valid is 1 and rd_stb is not pulsed sets overrun_err. That character is discarded and rx_data keeps the earlier byte.
- R7: While overrun_err is 1, no character is loaded. cont_en at 0 clears overrun_err on the next clock edge.
- R8: A one-cycle rd_stb clears rx_valid, unless a character completes in that same cycle.
- R9: A start bit is detected on a falling edge and must still be low at its middle. If the line is high at that point, the receiver goes back to idle and no flag changes.
- R10: After reset, rx_data, rx_bit9, rx_valid, frame_err and overrun_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| baud_div | input | DIV_W | Bit-rate divisor N |
| fast_mode | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| port_en | input | 1 | Serial port enable |
| cont_en | input | 1 | Continuous receive enable; 0 clears overrun |
| nine_mode | input | 1 | 1: receive a ninth data bit |
| rd_stb | input | 1 | One-cycle read strobe |
| rx_data | output | DATA_W | Held character |
| rx_bit9 | output | 1 | Ninth bit of held character |
| rx_valid | output | 1 | Held character not yet read |
| frame_err | output | 1 | Stop bit of held character was low |
| overrun_err | output | 1 | A character was lost to an unread one |

## Verification
The assertions assume that baud_div, fast_mode and nine_mode stay fixed while a character is in flight. They also assume that rd_stb lasts only one cycle at a time. The stimulus changes these settings only while the line has been idle for at least one bit time. Frames are driven on the falling clock edge at the exact bit length the requirements give. The receiver samples at the middle of each bit, so synchronizer latency never moves a sample across a bit boundary.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_EXTRA,
      PH_STOP
   } rx_phase_e;

   function automatic int width_for(input int count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt == divisor);
   assign tick = wrap && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (restart || wrap) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
   import serial_rx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int FAST_OSR = 16,
   parameter int SLOW_OSR = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fast,
   input  logic              nine,
   input  logic              rx_s,
   input  logic              tick,
   output logic              restart,
   output logic              done,
   output logic [DATA_W-1:0] shreg,
   output logic              extra_bit,
   output logic              stop_ok
);

   localparam int SUB_W = width_for(SLOW_OSR);
   localparam int IDX_W = width_for(DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   rx_phase_e        phase;
   logic [SUB_W-1:0] sub_cnt;
   logic [IDX_W-1:0] bit_idx;
   logic             rx_prev;
   logic [SUB_W-1:0] lim_full;
   logic [SUB_W-1:0] lim_half;
   logic             at_full;
   logic             at_half;
   logic             fall;

   assign lim_full = fast ? SUB_W'(FAST_OSR - 1)     : SUB_W'(SLOW_OSR - 1);
   assign lim_half = fast ? SUB_W'(FAST_OSR / 2 - 1) : SUB_W'(SLOW_OSR / 2 - 1);
   assign at_full  = tick && (sub_cnt == lim_full);
   assign at_half  = tick && (sub_cnt == lim_half);
   assign fall     = rx_prev && !rx_s;
   assign restart  = (phase == PH_IDLE);
   assign done     = enable && (phase == PH_STOP) && at_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev <= 1'b1;
      else        rx_prev <= rx_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         sub_cnt   <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         extra_bit <= 1'b0;
         stop_ok   <= 1'b0;
      end else if (!enable) begin
         phase   <= PH_IDLE;
         sub_cnt <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               sub_cnt <= '0;
               if (fall) begin
                  phase     <= PH_START;
                  extra_bit <= 1'b0;
               end
            end
            PH_START: begin
               if (at_half) begin
                  sub_cnt <= '0;
                  bit_idx <= '0;
                  phase   <= rx_s ? PH_IDLE : PH_DATA;
               end else if (tick) begin
                  sub_cnt <= sub_cnt + 1'b1;
               end
            end
            PH_DATA: begin
               if (at_full) begin
                  sub_cnt <= '0;
                  shreg   <= {rx_s, shreg[DATA_W-1:1]};
                  bit_idx <= bit_idx + 1'b1;
                  if (bit_idx == LAST_IDX) phase <= nine ? PH_EXTRA : PH_STOP;
               end else if (tick) begin
                  sub_cnt <= sub_cnt + 1'b1;
               end
            end
            PH_EXTRA: begin
               if (at_full) begin
                  sub_cnt   <= '0;
                  extra_bit <= rx_s;
                  phase     <= PH_STOP;
               end else if (tick) begin
                  sub_cnt <= sub_cnt + 1'b1;
               end
            end
            PH_STOP: begin
               if (at_full) begin
                  sub_cnt <= '0;
                  stop_ok <= rx_s;
                  phase   <= PH_IDLE;
               end else if (tick) begin
                  sub_cnt <= sub_cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cont_en,
   input  logic              done,
   input  logic [DATA_W-1:0] new_data,
   input  logic              new_bit9,
   input  logic              new_stop_ok,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] data_q,
   output logic              bit9_q,
   output logic              valid_q,
   output logic              ferr_q,
   output logic              ovr_q
);

   logic take;
   logic lose;

   assign take = done && !ovr_q && (!valid_q || rd_stb);
   assign lose = done && !ovr_q && valid_q && !rd_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         bit9_q  <= 1'b0;
         ferr_q  <= 1'b0;
         valid_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (take) begin
            data_q <= new_data;
            bit9_q <= new_bit9;
            ferr_q <= !new_stop_ok;
         end
         if (take)        valid_q <= 1'b1;
         else if (rd_stb) valid_q <= 1'b0;
         if (!cont_en)    ovr_q <= 1'b0;
         else if (lose)   ovr_q <= 1'b1;
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import serial_rx_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FAST_OSR    = 16,
   parameter int SLOW_OSR    = 64,
   parameter bit HAS_BIT9    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              fast_mode,
   input  logic              port_en,
   input  logic              cont_en,
   input  logic              nine_mode,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              rx_valid,
   output logic              frame_err,
   output logic              overrun_err
);

   initial begin
      assert (DIV_W >= 1) else $error("DIV_W must be at least 1");
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (FAST_OSR >= 4 && (FAST_OSR % 2) == 0) else $error("FAST_OSR must be even and >= 4");
      assert (SLOW_OSR >= FAST_OSR && (SLOW_OSR % 2) == 0) else $error("SLOW_OSR must be even and >= FAST_OSR");
   end

   logic              rx_s;
   logic              tick;
   logic              restart;
   logic              frame_done;
   logic [DATA_W-1:0] shreg;
   logic              extra_bit;
   logic              stop_ok;
   logic              rx_on;
   logic              nine_eff;

   assign rx_on = port_en && cont_en;

   generate
      if (HAS_BIT9) begin : g_bit9
         assign nine_eff = nine_mode;
      end else begin : g_no_bit9
         assign nine_eff = 1'b0;
      end
   endgenerate

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (rx_s)
   );

   serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .divisor(baud_div),
      .tick   (tick)
   );

   serial_rx_framer #(
      .DATA_W  (DATA_W),
      .FAST_OSR(FAST_OSR),
      .SLOW_OSR(SLOW_OSR)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (rx_on),
      .fast     (fast_mode),
      .nine     (nine_eff),
      .rx_s     (rx_s),
      .tick     (tick),
      .restart  (restart),
      .done     (frame_done),
      .shreg    (shreg),
      .extra_bit(extra_bit),
      .stop_ok  (stop_ok)
   );

   // the stop sample is registered, so the hold stage sees it one cycle late
   logic done_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= frame_done;
   end

   serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .cont_en    (cont_en),
      .done       (done_q),
      .new_data   (shreg),
      .new_bit9   (extra_bit),
      .new_stop_ok(stop_ok),
      .rd_stb     (rd_stb),
      .data_q     (rx_data),
      .bit9_q     (rx_bit9),
      .valid_q    (rx_valid),
      .ferr_q     (frame_err),
      .ovr_q      (overrun_err)
   );

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              port_en,
   input logic              cont_en,
   input logic              rd_stb,
   input logic              load_evt,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_valid,
   input logic              frame_err,
   input logic              overrun_err
);

   // R8
   rd_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rd_stb && !load_evt |=> !rx_valid);

   // R7
   cren_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cont_en |=> !overrun_err);

   // R6
   hold_while_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_err |=> $stable(rx_data));

   // R2
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en && cont_en) && !rx_valid |=> !rx_valid);

   // R3
   valid_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(load_evt));

   // R5
   ferr_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_err) |-> $past(load_evt));

endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .port_en    (port_en),
   .cont_en    (cont_en),
   .rd_stb     (rd_stb),
   .load_evt   (done_q),
   .rx_data    (rx_data),
   .rx_valid   (rx_valid),
   .frame_err  (frame_err),
   .overrun_err(overrun_err)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic [7:0] baud_div = 8'd0;
   logic       fast_mode = 1'b1;
   logic       port_en = 1'b1;
   logic       cont_en = 1'b1;
   logic       nine_mode = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9;
   logic       rx_valid;
   logic       frame_err;
   logic       overrun_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   serial_rx_core uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_div(baud_div),
      .fast_mode(fast_mode), .port_en(port_en), .cont_en(cont_en),
      .nine_mode(nine_mode), .rd_stb(rd_stb), .rx_data(rx_data),
      .rx_bit9(rx_bit9), .rx_valid(rx_valid), .frame_err(frame_err),
      .overrun_err(overrun_err)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done_flag) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int bit_clks();
      return (fast_mode ? 16 : 64) * (int'(baud_div) + 1);
   endfunction

   task automatic hold_line(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] v, input bit stop_hi);
      int bc;
      bc = bit_clks();
      hold_line(1'b0, bc);
      for (int i = 0; i < 8; i++) hold_line(v[i], bc);
      if (nine_mode) hold_line(v[8], bc);
      hold_line(stop_hi, bc);
      hold_line(1'b1, bc);
   endtask

   task automatic read_pulse();
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 data", rx_data, 0);
      chk("R10 valid", rx_valid, 0);
      chk("R10 bit9", rx_bit9, 0);
      chk("R10 ferr", frame_err, 0);
      chk("R10 ovr", overrun_err, 0);

      // R3 / R8: every byte, fast mode, divisor 0
      for (int b = 0; b < 256; b++) begin
         send({1'b0, 8'(b)}, 1'b1);
         chk("R3 valid", rx_valid, 1);
         chk("R3 data", rx_data, b);
         chk("R4 bit9 zero in 8-bit mode", rx_bit9, 0);
         chk("R5 ferr clear", frame_err, 0);
         read_pulse();
         chk("R8 read clears valid", rx_valid, 0);
      end

      // R1: other divisors and slow mode
      for (int cfg = 0; cfg < 4; cfg++) begin
         baud_div  = 8'(cfg % 2 == 0 ? 2 : 1);
         fast_mode = (cfg < 2);
         hold_line(1'b1, bit_clks());
         for (int k = 0; k < 3; k++) begin
            logic [7:0] pat;
            pat = 8'(8'h35 * (k + 1) + cfg * 8'h4b);
            send({1'b0, pat}, 1'b1);
            chk("R1 rate data", rx_data, pat);
            chk("R1 rate valid", rx_valid, 1);
            read_pulse();
         end
      end
      baud_div = 8'd0; fast_mode = 1'b1;
      hold_line(1'b1, 16);

      // R4: nine-bit mode
      nine_mode = 1'b1;
      hold_line(1'b1, 16);
      for (int n = 0; n < 32; n++) begin
         logic [8:0] w;
         w = 9'((n * 9'd83 + 9'd17) ^ (n << 4));
         send(w, 1'b1);
         chk("R4 data", rx_data, w[7:0]);
         chk("R4 ninth bit", rx_bit9, w[8]);
         read_pulse();
      end
      nine_mode = 1'b0;
      hold_line(1'b1, 16);

      // R5: framing error follows held character
      send(9'h0c3, 1'b0);
      chk("R5 ferr set", frame_err, 1);
      chk("R5 data kept", rx_data, 8'hc3);
      read_pulse();
      send(9'h03c, 1'b1);
      chk("R5 ferr cleared by good frame", frame_err, 0);
      read_pulse();

      // R6 / R7: overrun
      send(9'h0a1, 1'b1);
      send(9'h0b2, 1'b1);
      chk("R6 overrun set", overrun_err, 1);
      chk("R6 old data kept", rx_data, 8'ha1);
      read_pulse();
      send(9'h0c4, 1'b1);
      chk("R7 no load while overrun", rx_valid, 0);
      chk("R7 data unchanged", rx_data, 8'ha1);
      cont_en = 1'b0;
      @(negedge clk);
      chk("R7 overrun cleared", overrun_err, 0);
      cont_en = 1'b1;
      hold_line(1'b1, 16);
      send(9'h0d5, 1'b1);
      chk("R7 load resumes", rx_data, 8'hd5);
      read_pulse();

      // R9: false start
      hold_line(1'b0, 4);
      hold_line(1'b1, 48);
      chk("R9 no valid", rx_valid, 0);
      chk("R9 no ferr", frame_err, 0);
      chk("R9 no ovr", overrun_err, 0);
      send(9'h05a, 1'b1);
      chk("R9 next frame ok", rx_data, 8'h5a);
      read_pulse();

      // R2: disabled receiver
      port_en = 1'b0;
      send(9'h077, 1'b1);
      chk("R2 port off", rx_valid, 0);
      port_en = 1'b1; cont_en = 1'b0;
      send(9'h066, 1'b1);
      chk("R2 cont off", rx_valid, 0);
      chk("R2 data unchanged", rx_data, 8'h5a);
      cont_en = 1'b1;
      hold_line(1'b1, 16);

      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule